// File: doc/BRIEF.md
# Command Method Decoder and Validator

This block sits behind a command FIFO and takes one method/data pair at a time. It turns the 11-bit method index into an action by walking a sorted range table held in ROM. Each range has a start index, a count, and that many slots. A slot either names a state register that keeps the data word, or names a command that is announced with a one-cycle strobe. Each slot also holds a reserved-bit mask. A data word with any reserved bit set is refused.

A refused pair does not disturb any register or strobe. This happens for an index that no range covers, and for a data word that breaks the mask. Instead the block builds an exception word: the method index sits in bits 26:16 and an error code sits in bits 1:0. The block latches this word together with the offending data and raises a level interrupt toward the host. It then holds until the host acknowledges. Every pair, good or bad, ends in exactly one FIFO-pop pulse. The input stays not-ready from acceptance until that pulse.

Top module: `method_decoder`

## Requirements
- R1: After reset, cmdReady is 1, and irqReq, popPulse, cmdStrobe, excWord, excData and all state registers are 0.
- R2: The table is, in range order 0..4: index 0x000 -> register 0; 0x040,0x041 -> commands 0,1; 0x080..0x083 -> registers 1..4; 0x0C0 -> command 2; 0x0C3..0x0C5 -> registers 5..7. A final terminator range starts at 0x800 with count 0. State register n occupies stateRegs bits [32n+31:32n], and command n drives cmdStrobe bit n.
- R3: A lookup that stops because the index is below the current range's start is an illegal method. This covers gaps and every index past the last range, up to 0x7FF. The code is 1, and excWord = (index << 16) | 1.
- R4: Reserved masks are: register 1 0xFFFFF000, register 2 0xFFF80000, register 3 0xFFFFE000, register 4 0x0000000F, command 2 0xFFFFE000, register 5 0xFFFFFF00, register 6 0x0000000F; all other slots 0. Data with a masked bit set is an invalid bitfield: code 3, excWord = (index << 16) | 3.
- R5: A valid register slot stores the data word into its register. No other register changes.
- R6: A valid command slot pulses its cmdStrobe bit for one cycle, together with popPulse, and no register changes.
- R7: On any error, excData holds the offending data and irqReq rises and stays high until irqAck. No pop happens before the acknowledge. The cycle after the acknowledge, irqReq is 0 and popPulse is 1.
- R8: Each accepted pair yields exactly one single-cycle popPulse. cmdReady is 0 from the cycle after acceptance until the pop.
- R9: An error changes no state register and fires no command strobe.
- R10: The search examines one range per clock. For a hit in range k, popPulse is high k+2 cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A method/data pair is offered |
| cmdReady | output | 1 | Decoder can accept a pair |
| cmdMethod | input | 11 | Method index |
| cmdData | input | 32 | Data word of the method |
| popPulse | output | 1 | One-cycle FIFO-pop per handled pair |
| stateRegs | output | 256 | Eight 32-bit state registers, register n at bits 32n+31:32n |
| cmdStrobe | output | 3 | One-cycle command strobes |
| irqReq | output | 1 | Host interrupt request, level |
| irqAck | input | 1 | Host acknowledge of the interrupt |
| excWord | output | 32 | Last exception word: index in 26:16, code in 1:0 |
| excData | output | 32 | Data word of the last refused pair |

## Verification
The stimulus touches every slot of every range with a data word that fits its mask. This shows that the slot offset inside a range and the skip across earlier ranges both land on the right register or strobe, and the measured latency shows the range position. The same slots then get words with exactly one masked bit set, or a bit just outside the mask, which separates the invalid-bitfield path from a write. Indexes one below and one above each range, the gap between ranges, and 0x7FF exercise the illegal path and the terminator. After every pop a full comparison of all registers against a model shows that refused pairs and commands left the stored state alone.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  localparam int DATA_W      = 32;
  localparam int IDX_W       = 11;
  localparam int NUM_RANGES  = 6;
  localparam int NUM_SLOTS   = 11;
  localparam int NUM_REGS    = 8;
  localparam int NUM_CMDS    = 3;
  localparam int CODE_W      = 2;
  localparam int EXC_SHIFT   = 16;

  localparam int RANGE_PTR_W = $clog2(NUM_RANGES);
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int REG_SEL_W   = $clog2(NUM_REGS);
  localparam int CMD_SEL_W   = $clog2(NUM_CMDS);
  localparam int TARGET_W    = (REG_SEL_W > CMD_SEL_W) ? REG_SEL_W : CMD_SEL_W;
  localparam int START_W     = IDX_W + 1;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL = 2'b01;
  localparam logic [CODE_W-1:0] CODE_INVALID = 2'b11;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic advance;
    logic latchHit;
    logic writeReg;
    logic fireCmd;
    logic raiseIllegal;
    logic raiseInvalid;
    logic pop;
  } mdec_ctrl_t;

  typedef struct packed {
    logic [DATA_W-1:0]   mask;
    logic                isCmd;
    logic [TARGET_W-1:0] target;
  } slot_t;

  // range starts, ascending; last entry is the terminator
  function automatic logic [START_W-1:0] rangeStart(input logic [RANGE_PTR_W-1:0] r);
    case (r)
      3'd0:    rangeStart = START_W'('h000);
      3'd1:    rangeStart = START_W'('h040);
      3'd2:    rangeStart = START_W'('h080);
      3'd3:    rangeStart = START_W'('h0C0);
      3'd4:    rangeStart = START_W'('h0C3);
      default: rangeStart = START_W'('h800);
    endcase
  endfunction

  function automatic logic [START_W-1:0] rangeCount(input logic [RANGE_PTR_W-1:0] r);
    case (r)
      3'd0:    rangeCount = START_W'(1);
      3'd1:    rangeCount = START_W'(2);
      3'd2:    rangeCount = START_W'(4);
      3'd3:    rangeCount = START_W'(1);
      3'd4:    rangeCount = START_W'(3);
      default: rangeCount = START_W'(0);
    endcase
  endfunction

  function automatic slot_t slotEntry(input logic [SLOT_W-1:0] s);
    slot_t e;
    e = '{mask: '0, isCmd: 1'b0, target: '0};
    case (s)
      4'd0:  e = '{mask: 32'h0000_0000, isCmd: 1'b0, target: TARGET_W'(0)};
      4'd1:  e = '{mask: 32'h0000_0000, isCmd: 1'b1, target: TARGET_W'(0)};
      4'd2:  e = '{mask: 32'h0000_0000, isCmd: 1'b1, target: TARGET_W'(1)};
      4'd3:  e = '{mask: 32'hFFFF_F000, isCmd: 1'b0, target: TARGET_W'(1)};
      4'd4:  e = '{mask: 32'hFFF8_0000, isCmd: 1'b0, target: TARGET_W'(2)};
      4'd5:  e = '{mask: 32'hFFFF_E000, isCmd: 1'b0, target: TARGET_W'(3)};
      4'd6:  e = '{mask: 32'h0000_000F, isCmd: 1'b0, target: TARGET_W'(4)};
      4'd7:  e = '{mask: 32'hFFFF_E000, isCmd: 1'b1, target: TARGET_W'(2)};
      4'd8:  e = '{mask: 32'hFFFF_FF00, isCmd: 1'b0, target: TARGET_W'(5)};
      4'd9:  e = '{mask: 32'h0000_000F, isCmd: 1'b0, target: TARGET_W'(6)};
      4'd10: e = '{mask: 32'h0000_0000, isCmd: 1'b0, target: TARGET_W'(7)};
      default: e = '{mask: '0, isCmd: 1'b0, target: '0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/mdec_control.sv
module mdec_control
  import mdec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  input  logic       belowStart,
  input  logic       inRange,
  input  logic       maskFail,
  input  logic       slotIsCmd,
  input  logic       irqAck,
  output mdec_ctrl_t ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_EXEC, ST_WAIT} state_t;
  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign cmdReady = (state == ST_IDLE);

  always_comb begin
    nextState = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          ctrl.capture = 1'b1;
          nextState    = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (belowStart) begin
          ctrl.raiseIllegal = 1'b1;
          nextState         = ST_WAIT;
        end else if (inRange) begin
          ctrl.latchHit = 1'b1;
          nextState     = ST_EXEC;
        end else begin
          ctrl.advance = 1'b1;
        end
      end
      ST_EXEC: begin
        if (maskFail) begin
          ctrl.raiseInvalid = 1'b1;
          nextState         = ST_WAIT;
        end else begin
          ctrl.fireCmd  = slotIsCmd;
          ctrl.writeReg = !slotIsCmd;
          ctrl.pop      = 1'b1;
          nextState     = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (irqAck) begin
          ctrl.pop  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mdec_datapath.sv
module mdec_datapath
  import mdec_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  mdec_ctrl_t                   ctrl,
  input  logic [IDX_W-1:0]             cmdMethod,
  input  logic [DATA_W-1:0]            cmdData,
  output logic                         belowStart,
  output logic                         inRange,
  output logic                         maskFail,
  output logic                         slotIsCmd,
  output logic [NUM_REGS*DATA_W-1:0]   stateRegs,
  output logic [NUM_CMDS-1:0]          cmdStrobe,
  output logic                         popPulse,
  output logic                         irqReq,
  output logic [DATA_W-1:0]            excWord,
  output logic [DATA_W-1:0]            excData
);

  logic [IDX_W-1:0]       methodIdx;
  logic [DATA_W-1:0]      dataReg;
  logic [RANGE_PTR_W-1:0] rangePtr;
  logic [SLOT_W-1:0]      slotBase;
  logic [SLOT_W-1:0]      slotReg;

  logic [START_W-1:0] curStart;
  logic [START_W-1:0] curCount;
  logic [START_W-1:0] idxExt;
  logic [START_W-1:0] idxOffset;
  logic [SLOT_W-1:0]  hitSlot;
  slot_t              curSlot;

  // range walk status
  assign curStart   = rangeStart(rangePtr);
  assign curCount   = rangeCount(rangePtr);
  assign idxExt     = {1'b0, methodIdx};
  assign idxOffset  = idxExt - curStart;
  assign belowStart = idxExt < curStart;
  assign inRange    = idxExt < (curStart + curCount);
  assign hitSlot    = slotBase + SLOT_W'(idxOffset);

  // slot decode
  assign curSlot   = slotEntry(slotReg);
  assign maskFail  = |(dataReg & curSlot.mask);
  assign slotIsCmd = curSlot.isCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      methodIdx <= '0;
      dataReg   <= '0;
      rangePtr  <= '0;
      slotBase  <= '0;
      slotReg   <= '0;
    end else begin
      if (ctrl.capture) begin
        methodIdx <= cmdMethod;
        dataReg   <= cmdData;
        rangePtr  <= '0;
        slotBase  <= '0;
      end else if (ctrl.advance) begin
        rangePtr  <= rangePtr + RANGE_PTR_W'(1);
        slotBase  <= slotBase + SLOT_W'(curCount);
      end
      if (ctrl.latchHit) slotReg <= hitSlot;
    end
  end

  // state registers
  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN)
        stateRegs[g*DATA_W +: DATA_W] <= '0;
      else if (ctrl.writeReg && (curSlot.target == TARGET_W'(g)))
        stateRegs[g*DATA_W +: DATA_W] <= dataReg;
    end
  end

  // command strobes
  for (genvar g = 0; g < NUM_CMDS; g++) begin : gCmd
    always_ff @(posedge clk) begin
      if (!rstN) cmdStrobe[g] <= 1'b0;
      else       cmdStrobe[g] <= ctrl.fireCmd && (curSlot.target == TARGET_W'(g));
    end
  end

  // pop, interrupt and exception report
  always_ff @(posedge clk) begin
    if (!rstN) begin
      popPulse <= 1'b0;
      irqReq   <= 1'b0;
      excWord  <= '0;
      excData  <= '0;
    end else begin
      popPulse <= ctrl.pop;
      if (ctrl.raiseIllegal || ctrl.raiseInvalid) begin
        irqReq  <= 1'b1;
        excData <= dataReg;
        excWord <= (DATA_W'(methodIdx) << EXC_SHIFT)
                 | DATA_W'(ctrl.raiseInvalid ? CODE_INVALID : CODE_ILLEGAL);
      end else if (ctrl.pop) begin
        irqReq  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/method_decoder.sv
module method_decoder
  import mdec_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  output logic                       cmdReady,
  input  logic [IDX_W-1:0]           cmdMethod,
  input  logic [DATA_W-1:0]          cmdData,
  output logic                       popPulse,
  output logic [NUM_REGS*DATA_W-1:0] stateRegs,
  output logic [NUM_CMDS-1:0]        cmdStrobe,
  output logic                       irqReq,
  input  logic                       irqAck,
  output logic [DATA_W-1:0]          excWord,
  output logic [DATA_W-1:0]          excData
);

  mdec_ctrl_t ctrl;
  logic belowStart, inRange, maskFail, slotIsCmd;

  mdec_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdReady   (cmdReady),
    .belowStart (belowStart),
    .inRange    (inRange),
    .maskFail   (maskFail),
    .slotIsCmd  (slotIsCmd),
    .irqAck     (irqAck),
    .ctrl       (ctrl)
  );

  mdec_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cmdMethod  (cmdMethod),
    .cmdData    (cmdData),
    .belowStart (belowStart),
    .inRange    (inRange),
    .maskFail   (maskFail),
    .slotIsCmd  (slotIsCmd),
    .stateRegs  (stateRegs),
    .cmdStrobe  (cmdStrobe),
    .popPulse   (popPulse),
    .irqReq     (irqReq),
    .excWord    (excWord),
    .excData    (excData)
  );

endmodule

// File: rtl/mdec_checker.sv
module mdec_checker
  import mdec_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic                cmdReady,
  input logic                popPulse,
  input logic [NUM_CMDS-1:0] cmdStrobe,
  input logic                irqReq,
  input logic                irqAck
);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdReady);

  assert_pop_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    popPulse |=> !popPulse);

  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdStrobe));

  assert_strobe_with_pop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe != '0) |-> popPulse);

  assert_strobe_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe != '0) |=> (cmdStrobe == '0));

  assert_irq_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> (irqReq && !popPulse));

  assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> (!irqReq && popPulse));

  assert_irq_stalls_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !cmdReady);

  assert_no_strobe_on_error_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (cmdStrobe == '0));

endmodule

bind method_decoder mdec_checker u_mdec_checker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .popPulse  (popPulse),
  .cmdStrobe (cmdStrobe),
  .irqReq    (irqReq),
  .irqAck    (irqAck)
);

// File: tb/sim_method_decoder.sv
module sim_method_decoder;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdReady;
  logic [10:0]  cmdMethod = '0;
  logic [31:0]  cmdData = '0;
  logic         popPulse;
  logic [255:0] stateRegs;
  logic [2:0]   cmdStrobe;
  logic         irqReq;
  logic         irqAck = 1'b0;
  logic [31:0]  excWord;
  logic [31:0]  excData;

  always #(CLK_PERIOD/2) clk = ~clk;

  method_decoder u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdMethod(cmdMethod), .cmdData(cmdData), .popPulse(popPulse),
    .stateRegs(stateRegs), .cmdStrobe(cmdStrobe), .irqReq(irqReq),
    .irqAck(irqAck), .excWord(excWord), .excData(excData)
  );

  typedef struct {
    int          kind;     // 0 register, 1 command, 2 error
    int          target;
    logic [31:0] data;
    logic [31:0] expExc;
    int          dueCycle; // -1 for errors
  } item_t;

  item_t       sbQueue[$];
  logic [31:0] modelRegs[8];
  int          cycleCnt = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          sawIrq = 0;
  bit          prevPop = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model of the table
  function automatic void lookup(input int idx, input logic [31:0] data,
                                 output int kind, output int target,
                                 output logic [31:0] exc, output int rangePos);
    logic [31:0] mask;
    mask = 32'h0; kind = 0; target = 0; rangePos = 0; exc = 32'h0;
    if (idx == 0) begin
      kind = 0; target = 0; rangePos = 0;
    end else if (idx >= 'h40 && idx <= 'h41) begin
      kind = 1; target = idx - 'h40; rangePos = 1;
    end else if (idx >= 'h80 && idx <= 'h83) begin
      kind = 0; target = idx - 'h80 + 1; rangePos = 2;
      case (idx)
        'h80: mask = 32'hFFFFF000;
        'h81: mask = 32'hFFF80000;
        'h82: mask = 32'hFFFFE000;
        default: mask = 32'h0000000F;
      endcase
    end else if (idx == 'hC0) begin
      kind = 1; target = 2; rangePos = 3; mask = 32'hFFFFE000;
    end else if (idx >= 'hC3 && idx <= 'hC5) begin
      kind = 0; target = idx - 'hC3 + 5; rangePos = 4;
      mask = (idx == 'hC3) ? 32'hFFFFFF00 : (idx == 'hC4) ? 32'h0000000F : 32'h0;
    end else begin
      kind = 2; exc = (32'(idx) << 16) | 32'd1;
      return;
    end
    if ((data & mask) != 0) begin
      kind = 2; exc = (32'(idx) << 16) | 32'd3;
    end
  endfunction

  // driver
  task automatic send(input int idx, input logic [31:0] data);
    item_t it;
    int    pos;
    lookup(idx, data, it.kind, it.target, it.expExc, pos);
    it.data = data;
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid  = 1'b1;
    cmdMethod = 11'(idx);
    cmdData   = data;
    @(negedge clk);
    cmdValid  = 1'b0;
    it.dueCycle = (it.kind == 2) ? -1 : cycleCnt + pos + 2;
    sbQueue.push_back(it);
    check(cmdReady == 1'b0, "R8 busy after accept", 256'(cmdReady), 256'(0));
  endtask

  // host acknowledge
  initial begin
    forever begin
      @(negedge clk);
      if (irqReq) begin
        repeat (3) begin
          @(negedge clk);
          check(irqReq && !popPulse, "R7 irq held without ack", 256'({irqReq, popPulse}), 256'(2'b10));
        end
        irqAck = 1'b1;
        @(negedge clk);
        irqAck = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    item_t it;
    logic [255:0] expRegs;
    forever begin
      @(negedge clk);
      if (irqReq) sawIrq = 1;
      if (prevPop)
        check(!popPulse && cmdStrobe == 0, "R8 R6 pop and strobe last one cycle",
              256'({popPulse, cmdStrobe}), 256'(0));
      prevPop = popPulse;
      if (popPulse) begin
        if (sbQueue.size() == 0) begin
          check(0, "R8 pop without pending pair", 256'(1), 256'(0));
        end else begin
          it = sbQueue.pop_front();
          if (it.kind == 0) modelRegs[it.target] = it.data;
          for (int i = 0; i < 8; i++) expRegs[i*32 +: 32] = modelRegs[i];
          check(stateRegs == expRegs, "R5 R9 register file", stateRegs, expRegs);
          if (it.kind == 1)
            check(cmdStrobe == 3'(1 << it.target), "R6 command strobe", 256'(cmdStrobe), 256'(1 << it.target));
          else
            check(cmdStrobe == 0, "R9 no strobe", 256'(cmdStrobe), 256'(0));
          if (it.kind == 2) begin
            check(sawIrq == 1, "R7 irq raised", 256'(sawIrq), 256'(1));
            check(!irqReq, "R7 irq dropped with pop", 256'(irqReq), 256'(0));
            check(excWord == it.expExc, "R3 R4 exception word", 256'(excWord), 256'(it.expExc));
            check(excData == it.data, "R7 exception data", 256'(excData), 256'(it.data));
          end else begin
            check(sawIrq == 0, "R7 no irq on success", 256'(sawIrq), 256'(0));
            check(cycleCnt == it.dueCycle, "R10 search latency", 256'(cycleCnt), 256'(it.dueCycle));
          end
        end
        sawIrq = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) modelRegs[i] = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmdReady == 1'b1, "R1 ready", 256'(cmdReady), 256'(1));
    check(!irqReq && !popPulse && cmdStrobe == 0, "R1 controls idle",
          256'({irqReq, popPulse, cmdStrobe}), 256'(0));
    check(stateRegs == '0 && excWord == 0 && excData == 0, "R1 registers clear",
          stateRegs, 256'(0));

    // R2 R5 every register slot with fitting data
    send('h000, 32'h12345678);
    send('h080, 32'h00000ABC);
    send('h081, 32'h0007FFFF);
    send('h082, 32'h00001FFF);
    send('h083, 32'h0ABCDEF0);
    send('hC3,  32'h000000FF);
    send('hC4,  32'hFFFFFFF0);
    send('hC5,  32'hFFFFFFFF);
    // R6 commands
    send('h040, 32'hDEADBEEF);
    send('h041, 32'h00000000);
    send('hC0,  32'h00001FFF);
    // R4 invalid bitfields
    send('h080, 32'h00001000);
    send('hC0,  32'h00002000);
    send('h083, 32'h00000001);
    send('h081, 32'h00080000);
    send('hC4,  32'h00000008);
    // R3 illegal methods: gaps, edges, beyond last range, terminator
    send('h001, 32'h11111111);
    send('h03F, 32'h22222222);
    send('h042, 32'h33333333);
    send('h084, 32'h44444444);
    send('hC1,  32'h55555555);
    send('hC6,  32'h66666666);
    send('h7FF, 32'h77777777);
    // R5 overwrite after errors
    send('h000, 32'hCAFEF00D);
    send('hC5,  32'h00000001);

    while (sbQueue.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule